// File: doc/BRIEF.md
# Iterative Integer Square Root by Unit Stepping

This block finds the integer square root of an unsigned operand that is known to be a perfect square. A one-cycle start pulse captures a first estimate equal to the operand divided by four. On each later clock edge the block squares its current estimate and compares that square with the operand. If the square is too large, the estimate drops by one. If it is too small, the estimate rises by one. If the two are equal, the block raises its done flag and freezes the estimate.

The current estimate is always visible on the result port. The caller holds the operand steady from the start pulse until done goes high, and then reads the result. A new start pulse always takes effect, even while a search is running. Operands that are not perfect squares are outside the contract.

Top module: `isqrt_walk`

## Requirements
- R1: During and after synchronous reset, `root_o` is 0 and `done_o` is 0. Without a start pulse, both keep those values on every later edge.
- R2: On the edge where `start_i` is 1, `root_o` loads `value_i >> 2` (the operand divided by four, rounded down) and `done_o` goes to 0.
- R3: While a search is running and not yet done, if the square of `root_o` is greater than `value_i`, then `root_o` decreases by exactly one on the next edge.
- R4: While a search is running and not yet done, if the square of `root_o` is less than `value_i`, then `root_o` increases by exactly one on the next edge.
- R5: `done_o` rises on the edge after `root_o` squared first equals `value_i`. At that point `root_o` is the exact root.
- R6: While `done_o` is 1 and no start pulse arrives, `root_o` and `done_o` do not change.
- R7: A start pulse has priority over stepping and over done. When it arrives during a search or after completion, it reloads `value_i >> 2` and clears `done_o`.
- R8: An operand of 0 gives a first estimate of 0, and `done_o` rises one edge after the start edge.
- R9: `done_o` rises exactly |(value_i >> 2) − root| + 1 edges after the start edge. The worst 8-bit case is 225, which takes 42 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a new search |
| value_i | input | DATA_W | Operand (a perfect square), held stable until done |
| root_o | output | DATA_W | Current estimate of the root |
| done_o | output | 1 | High once the estimate squared equals the operand |

## Verification
The bench builds the block with the default 8-bit operand width. At that width, every perfect square from 0 to 225 can be reached directly. This covers the zero operand, the operand 1 where the first estimate is below the root, and the 225 case with the longest downward walk. Random operands are drawn as squares of random roots. A bench model tracks the estimate edge by edge and checks the direction of every step and the exact edge on which done rises. A reload in the middle of a search exercises the priority of start.

// File: rtl/isqrt_pkg.sv
package isqrt_pkg;
    localparam int DATA_W_DEF = 8;

    typedef struct packed {
        logic [DATA_W_DEF-1:0] est;
        logic                  done;
        logic                  busy;
    } walk_state_t;
endpackage

// File: rtl/isqrt_square.sv
module isqrt_square #(
    parameter int DATA_W = 8,
    localparam int SQ_W = 2 * DATA_W
) (
    input  logic [DATA_W-1:0] est_i,
    output logic [SQ_W-1:0]   sq_o
);
    // Full-width product, so the comparison never wraps
    always_comb begin
        sq_o = SQ_W'(est_i) * SQ_W'(est_i);
    end
endmodule

// File: rtl/isqrt_compare.sv
module isqrt_compare #(
    parameter int DATA_W = 8,
    localparam int SQ_W = 2 * DATA_W
) (
    input  logic [SQ_W-1:0]   sq_i,
    input  logic [DATA_W-1:0] value_i,
    output logic              above_o,
    output logic              match_o
);
    logic [SQ_W-1:0] value_ext;

    always_comb begin
        value_ext = SQ_W'(value_i);
        above_o   = sq_i > value_ext;
        match_o   = sq_i == value_ext;
    end
endmodule

// File: rtl/isqrt_step.sv
module isqrt_step #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] est_i,
    input  logic              down_i,
    output logic [DATA_W-1:0] est_o
);
    always_comb begin
        if (down_i) begin
            est_o = est_i - DATA_W'(1);
        end else begin
            est_o = est_i + DATA_W'(1);
        end
    end
endmodule

// File: rtl/isqrt_walk.sv
module isqrt_walk #(
    parameter int DATA_W = 8,
    localparam int SQ_W = 2 * DATA_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] value_i,
    output logic [DATA_W-1:0] root_o,
    output logic              done_o
);
    typedef struct packed {
        logic [DATA_W-1:0] est;
        logic              done;
        logic              busy;
    } state_t;

    state_t            st_q;
    state_t            st_d;
    logic [SQ_W-1:0]   sq;
    logic              above;
    logic              match;
    logic [DATA_W-1:0] stepped;

    isqrt_square #(.DATA_W(DATA_W)) u_square (
        .est_i (st_q.est),
        .sq_o  (sq)
    );

    isqrt_compare #(.DATA_W(DATA_W)) u_compare (
        .sq_i    (sq),
        .value_i (value_i),
        .above_o (above),
        .match_o (match)
    );

    isqrt_step #(.DATA_W(DATA_W)) u_step (
        .est_i  (st_q.est),
        .down_i (above),
        .est_o  (stepped)
    );

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.est  = value_i >> 2;
            st_d.done = 1'b0;
            st_d.busy = 1'b1;
        end else if (st_q.busy && !st_q.done) begin
            if (match) begin
                st_d.done = 1'b1;
            end else begin
                st_d.est = stepped;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign root_o = st_q.est;
    assign done_o = st_q.done;

    assert_start_load_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (root_o == ($past(value_i) >> 2)) && !done_o);

    assert_step_down_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.busy && !done_o && !start_i && above) |=> root_o == $past(root_o) - DATA_W'(1));

    assert_step_up_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.busy && !done_o && !start_i && !above && !match) |=> root_o == $past(root_o) + DATA_W'(1));

    assert_done_exact_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(done_o) |-> (SQ_W'(root_o) * SQ_W'(root_o)) == SQ_W'(value_i));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> done_o && $stable(root_o));

    assert_idle_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!st_q.busy && !start_i) |=> !done_o && $stable(root_o));
endmodule

// File: tb/tb_isqrt_walk.sv
module tb_isqrt_walk;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [W-1:0] value;
    logic [W-1:0] root;
    logic         done;
    int           n_run = 0;
    int           n_fail = 0;

    isqrt_walk #(.DATA_W(W)) dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .start_i (start),
        .value_i (value),
        .root_o  (root),
        .done_o  (done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int isqrt_ref(input int n);
        int r = 0;
        while ((r + 1) * (r + 1) <= n) r++;
        return r;
    endfunction

    function automatic int abs_i(input int a);
        return (a < 0) ? -a : a;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start a search and follow it to completion against a step model
    task automatic run(input int n);
        int g;
        int edges;
        int r;
        @(negedge clk);
        value = W'(n);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        g = n >> 2;
        r = isqrt_ref(n);
        check("R2 first estimate", int'(root), g);
        check("R2 done cleared", int'(done), 0);
        edges = 0;
        while (g * g != n && edges < 300) begin
            @(negedge clk);
            edges++;
            if (g * g > n) begin
                g--;
                check("R3 step down", int'(root), g);
            end else begin
                g++;
                check("R4 step up", int'(root), g);
            end
            check("R5 not yet done", int'(done), 0);
        end
        @(negedge clk);
        edges++;
        check("R5 done raised", int'(done), 1);
        check("R5 exact root", int'(root), r);
        check("R9 latency", edges, abs_i((n >> 2) - r) + 1);
        if (n == 0) check("R8 zero operand latency", edges, 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R6 hold root", int'(root), r);
            check("R6 hold done", int'(done), 1);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int rr;
        void'($urandom(32'd1234));
        rst = 1'b1;
        start = 1'b0;
        value = '0;
        repeat (3) @(negedge clk);
        check("R1 reset root", int'(root), 0);
        check("R1 reset done", int'(done), 0);
        rst = 1'b0;
        value = 8'd100;
        repeat (4) @(negedge clk);
        check("R1 idle root", int'(root), 0);
        check("R1 idle done", int'(done), 0);

        run(0);
        run(1);
        run(4);
        run(144);
        run(225);

        // R7: reload in the middle of a long search
        @(negedge clk);
        value = 8'd225;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        check("R7 mid-search progress", int'(root), 51);
        value = 8'd16;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R7 reload estimate", int'(root), 4);
        check("R7 reload clears done", int'(done), 0);
        @(negedge clk);
        check("R7 reload completes", int'(done), 1);
        check("R7 reload root", int'(root), 4);

        // R7: restart after completion clears done
        run(49);

        for (int t = 0; t < 25; t++) begin
            rr = int'($urandom_range(15, 0));
            run(rr * rr);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule